// File: doc/BRIEF.md
# Variable-Length Transmit Word Packer

This block sits between a 32-bit register write port and the byte-wide serial shifter of a flash SPI master. Software picks how many bytes of a written word are sent by the address it writes to: four addresses each enqueue one word, tagged with a byte count of one to four. The packer hands the shifter only the valid bytes of the oldest queued word, starting at the word's lowest byte. It collects the bytes clocked back in during that same entry into one receive word, which it emits as a single-cycle push toward a receive queue.

When two flash devices are driven in parallel, a data word with an odd byte count is extended by one byte so that neither device sees half a byte. Instruction words are never extended. The queue only accepts a new length while it is empty, so any switch between word lengths happens at a clean boundary. Writes that break this rule, or that arrive while the queue is full, are dropped and flagged.

Top module: `tx_word_packer`

## Requirements
- R1: A write with `wr_en` high queues `wr_data` with a byte count set by `wr_addr`: 0x80 gives 1 byte, 0x84 gives 2, 0x88 gives 3, 0x1C gives 4. A write to any other address queues nothing, raises no `wr_drop` and leaves `sh_valid` unchanged.
- R2: Byte k of a queued word is `wr_data[8k+7:8k]`. The bytes are offered on `sh_byte` in the order k = 0, 1, 2, and so on. Each entry starts at its own byte 0, with nothing carried over from the entry before it.
- R3: For an entry of n shifted bytes, the first received byte lands in bits [8(4-n)+7 : 8(4-n)] of `rx_word`. Each later byte goes one byte position higher. Bytes below position 4-n are zero.
- R4: `rx_push` is high for exactly the one cycle after the `sh_done` that completes an entry's last byte. It stays low after every other byte.
- R5: If `dual_par` is 1 and `instr_mode` is 0 at write time, an odd byte count is raised by one, and the extra byte is the next byte of `wr_data`. In all other cases the count is not changed.
- R6: While the queue holds at least one entry, a write whose byte count differs from the most recently queued entry is dropped, and `wr_drop` is high in that cycle. A write with the same count is accepted. When the queue is empty, any count is accepted.
- R7: The queue holds DEPTH entries (4 by default). A mapped write while it is full is dropped, with `wr_drop` high.
- R8: `sh_valid` is high exactly while an entry is pending. `sh_byte` holds steady until `sh_done`. A `sh_done` while `sh_valid` is low has no effect.
- R9: After reset the queue is empty, and `sh_valid`, `rx_push` and `wr_drop` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset, selects the byte count |
| wr_data | input | 32 | Write data, byte 0 is sent first |
| dual_par | input | 1 | Two devices in parallel, enables odd-count padding |
| instr_mode | input | 1 | Current write is an instruction (never padded) |
| wr_drop | output | 1 | Mapped write rejected this cycle |
| sh_valid | output | 1 | A transmit byte is offered |
| sh_byte | output | 8 | Transmit byte to the shifter |
| sh_done | input | 1 | Shifter finished the offered byte |
| sh_rx_byte | input | 8 | Byte received during the finished byte |
| rx_push | output | 1 | Receive word complete (one cycle) |
| rx_word | output | 32 | High-aligned receive word |

## Verification
Some rules are checked by the assertions on every cycle:
- the offered byte holds steady until the shifter finishes it;
- a receive push only ever follows a finished byte;
- a finish strobe with nothing offered produces no push;
- only mapped writes can be dropped.

The rest can only be shown by the bench's scenarios: the byte order, the high alignment of short receive words, the padding rules, and the length-switch and full-queue rejections. These depend on the value written and the address used, and the scenarios compare against bytes worked out from the requirements.

// File: rtl/txpk_pkg.sv
package txpk_pkg;
    // One queued transmit word with its length tag (count-1) and pad flag
    typedef struct packed {
        logic [31:0] data;
        logic [1:0]  tag;
        logic        pad;
    } txpk_entry_t;
endpackage

// File: rtl/txpk_queue.sv
module txpk_queue
    import txpk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  txpk_entry_t push_ent,
    input  logic        pop,
    output txpk_entry_t head,
    output logic        empty,
    output logic        full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t    st_q, st_d;
    txpk_entry_t mem_q [DEPTH];

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop && !empty) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({push && !full, pop && !empty})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem_q[st_q.wp] <= push_ent;
    end
endmodule

// File: rtl/txpk_rxpack.sv
module txpk_rxpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_done,
    input  logic        last_byte,
    input  logic [7:0]  rx_byte,
    output logic [31:0] word,
    output logic        push
);
    typedef struct packed {
        logic [31:0] acc;
        logic [31:0] word;
        logic        push;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic [31:0] shifted;

    assign word = st_q.word;
    assign push = st_q.push;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        // New byte enters at the top; earlier bytes move down one lane
        shifted   = {rx_byte, st_q.acc[31:8]};
        if (byte_done) begin
            if (last_byte) begin
                st_d.word = shifted;
                st_d.push = 1'b1;
                st_d.acc  = '0;
            end else begin
                st_d.acc  = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer
    import txpk_pkg::*;
#(
    parameter int         DEPTH  = 4,
    parameter logic [7:0] OFS_B1 = 8'h80,
    parameter logic [7:0] OFS_B2 = 8'h84,
    parameter logic [7:0] OFS_B3 = 8'h88,
    parameter logic [7:0] OFS_B4 = 8'h1C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        dual_par,
    input  logic        instr_mode,
    output logic        wr_drop,
    output logic        sh_valid,
    output logic [7:0]  sh_byte,
    input  logic        sh_done,
    input  logic [7:0]  sh_rx_byte,
    output logic        rx_push,
    output logic [31:0] rx_word
);
    typedef struct packed {
        logic [1:0] idx;
        logic [1:0] last_tag;
    } top_state_t;

    top_state_t  st_q, st_d;
    txpk_entry_t new_ent, head;
    logic        q_empty, q_full;
    logic        hit, accept, advance, last_byte;
    logic [1:0]  tag;
    logic [2:0]  head_cnt;

    always_comb begin
        hit = wr_en;
        tag = 2'd3;
        unique case (wr_addr)
            OFS_B1:  tag = 2'd0;
            OFS_B2:  tag = 2'd1;
            OFS_B3:  tag = 2'd2;
            OFS_B4:  tag = 2'd3;
            default: hit = 1'b0;
        endcase
    end

    assign accept       = hit && !q_full && (q_empty || tag == st_q.last_tag);
    assign wr_drop      = hit && !accept;
    assign new_ent.data = wr_data;
    assign new_ent.tag  = tag;
    // Tag 0 and 2 mean odd byte counts
    assign new_ent.pad  = dual_par && !instr_mode && !tag[0];

    assign head_cnt  = {1'b0, head.tag} + 3'd1 + {2'b00, head.pad};
    assign sh_valid  = !q_empty;
    assign sh_byte   = head.data[8*st_q.idx +: 8];
    assign advance   = sh_done && !q_empty;
    assign last_byte = ({1'b0, st_q.idx} == head_cnt - 3'd1);

    always_comb begin
        st_d = st_q;
        if (accept) st_d.last_tag = tag;
        if (advance) st_d.idx = last_byte ? 2'd0 : st_q.idx + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    txpk_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_ent (new_ent),
        .pop      (advance && last_byte),
        .head     (head),
        .empty    (q_empty),
        .full     (q_full)
    );

    txpk_rxpack u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (advance),
        .last_byte (last_byte),
        .rx_byte   (sh_rx_byte),
        .word      (rx_word),
        .push      (rx_push)
    );
endmodule

// File: rtl/txpk_chk.sv
module txpk_chk #(
    parameter logic [7:0] OFS_B1 = 8'h80,
    parameter logic [7:0] OFS_B2 = 8'h84,
    parameter logic [7:0] OFS_B3 = 8'h88,
    parameter logic [7:0] OFS_B4 = 8'h1C
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       wr_drop,
    input logic       sh_valid,
    input logic [7:0] sh_byte,
    input logic       sh_done,
    input logic       rx_push
);
    logic mapped;
    assign mapped = (wr_addr == OFS_B1) || (wr_addr == OFS_B2) ||
                    (wr_addr == OFS_B3) || (wr_addr == OFS_B4);

    // R8
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_valid && !sh_done |=> sh_valid && $stable(sh_byte));

    // R4
    push_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_push) |-> $past(sh_done) && $past(sh_valid));

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done && !sh_valid |=> !rx_push);

    // R1
    unmapped_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && mapped) |-> !wr_drop);

    // R6
    drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> wr_en);
endmodule

bind tx_word_packer txpk_chk #(
    .OFS_B1(OFS_B1), .OFS_B2(OFS_B2), .OFS_B3(OFS_B3), .OFS_B4(OFS_B4)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_drop(wr_drop), .sh_valid(sh_valid), .sh_byte(sh_byte),
    .sh_done(sh_done), .rx_push(rx_push)
);

// File: tb/tx_word_packer_test.sv
module tx_word_packer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        dual_par = 1'b0;
    logic        instr_mode = 1'b0;
    logic        wr_drop;
    logic        sh_valid;
    logic [7:0]  sh_byte;
    logic        sh_done = 1'b0;
    logic [7:0]  sh_rx_byte = '0;
    logic        rx_push;
    logic [31:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_word_packer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dual_par(dual_par), .instr_mode(instr_mode),
        .wr_drop(wr_drop), .sh_valid(sh_valid), .sh_byte(sh_byte),
        .sh_done(sh_done), .sh_rx_byte(sh_rx_byte), .rx_push(rx_push),
        .rx_word(rx_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Write one word; every task starts and ends at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit exp_drop,
                      input string req);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk(wr_drop == exp_drop, req, 32'(wr_drop), 32'(exp_drop));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xb(input logic [7:0] exp_tx, input logic [7:0] rx, input bit last,
                      input string req);
        chk(sh_valid == 1'b1, req, 32'(sh_valid), 32'd1);
        chk(sh_byte == exp_tx, req, 32'(sh_byte), 32'(exp_tx));
        sh_done = 1'b1; sh_rx_byte = rx;
        @(negedge clk);
        sh_done = 1'b0;
        if (!last) chk(rx_push == 1'b0, "R4", 32'(rx_push), 32'd0);
    endtask

    // Shift n bytes of data; rx bytes come from rxs, low byte first
    task automatic entry(input logic [31:0] data, input int n, input logic [31:0] rxs,
                         input string req);
        logic [31:0] expw;
        expw = '0;
        for (int k = 0; k < n; k++) begin
            xb(data[8*k +: 8], rxs[8*k +: 8], k == n - 1, req);
            expw[8*(4 - n + k) +: 8] = rxs[8*k +: 8];
        end
        chk(rx_push == 1'b1, "R4", 32'(rx_push), 32'd1);
        chk(rx_word == expw, "R3", rx_word, expw);
        @(negedge clk);
        chk(rx_push == 1'b0, "R4", 32'(rx_push), 32'd0);
    endtask

    task automatic t_reset();
        chk(sh_valid == 1'b0, "R9", 32'(sh_valid), 32'd0);
        chk(rx_push == 1'b0, "R9", 32'(rx_push), 32'd0);
        chk(wr_drop == 1'b0, "R9", 32'(wr_drop), 32'd0);
    endtask

    task automatic t_lengths();
        wr(8'h1C, 32'h44332211, 1'b0, "R1");
        entry(32'h44332211, 4, 32'hA3A2A1A0, "R2");
        wr(8'h80, 32'hFFFFFF5A, 1'b0, "R1");
        entry(32'hFFFFFF5A, 1, 32'h000000C7, "R1");
        wr(8'h84, 32'h1234BEEF, 1'b0, "R1");
        entry(32'h1234BEEF, 2, 32'h00000201, "R1");
        wr(8'h88, 32'h00CCBBAA, 1'b0, "R1");
        entry(32'h00CCBBAA, 3, 32'h00302010, "R3");
    endtask

    task automatic t_back_to_back();
        wr(8'h88, 32'h99332211, 1'b0, "R2");
        wr(8'h88, 32'h88665544, 1'b0, "R2");
        entry(32'h99332211, 3, 32'h00030201, "R2");
        entry(32'h88665544, 3, 32'h00060504, "R2");
        chk(sh_valid == 1'b0, "R8", 32'(sh_valid), 32'd0);
    endtask

    task automatic t_pad();
        dual_par = 1'b1; instr_mode = 1'b0;
        wr(8'h80, 32'hFFFFFF77, 1'b0, "R5");
        entry(32'hFFFFFF77, 2, 32'h00002211, "R5");
        wr(8'h88, 32'hDDCCBBAA, 1'b0, "R5");
        entry(32'hDDCCBBAA, 4, 32'h44332211, "R5");
        wr(8'h84, 32'hDDCCBBAA, 1'b0, "R5");
        entry(32'hDDCCBBAA, 2, 32'h00006655, "R5");
        instr_mode = 1'b1;
        wr(8'h80, 32'hFFFFFF9C, 1'b0, "R5");
        entry(32'hFFFFFF9C, 1, 32'h00000077, "R5");
        dual_par = 1'b0; instr_mode = 1'b0;
    endtask

    task automatic t_switch();
        wr(8'h1C, 32'h0D0C0B0A, 1'b0, "R6");
        wr(8'h80, 32'h000000EE, 1'b1, "R6");
        wr(8'h1C, 32'h1D1C1B1A, 1'b0, "R6");
        entry(32'h0D0C0B0A, 4, 32'h04030201, "R6");
        entry(32'h1D1C1B1A, 4, 32'h08070605, "R6");
        chk(sh_valid == 1'b0, "R6", 32'(sh_valid), 32'd0);
        wr(8'h80, 32'h000000EE, 1'b0, "R6");
        entry(32'h000000EE, 1, 32'h00000042, "R6");
    endtask

    task automatic t_full();
        for (int e = 0; e < 4; e++) wr(8'h1C, 32'h01010101 * (e + 1), 1'b0, "R7");
        wr(8'h1C, 32'hFEFEFEFE, 1'b1, "R7");
        for (int e = 0; e < 4; e++)
            entry(32'h01010101 * (e + 1), 4, 32'h10101010 * (e + 1), "R7");
        chk(sh_valid == 1'b0, "R7", 32'(sh_valid), 32'd0);
    endtask

    task automatic t_ignore();
        wr(8'h20, 32'hCAFEF00D, 1'b0, "R1");
        chk(sh_valid == 1'b0, "R1", 32'(sh_valid), 32'd0);
        wr(8'h40, 32'hCAFEF00D, 1'b0, "R1");
        chk(sh_valid == 1'b0, "R1", 32'(sh_valid), 32'd0);
        sh_done = 1'b1; sh_rx_byte = 8'h55;
        @(negedge clk);
        sh_done = 1'b0;
        chk(rx_push == 1'b0, "R8", 32'(rx_push), 32'd0);
        chk(sh_valid == 1'b0, "R8", 32'(sh_valid), 32'd0);
        wr(8'h84, 32'h0000B2B1, 1'b0, "R8");
        for (int i = 0; i < 3; i++) begin
            chk(sh_byte == 8'hB1, "R8", 32'(sh_byte), 32'hB1);
            @(negedge clk);
        end
        entry(32'h0000B2B1, 2, 32'h00000E0D, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_back_to_back();
        t_pad();
        t_switch();
        t_full();
        t_ignore();
        summary();
    end
endmodule